// File: doc/BRIEF.md
# Exception and Interrupt Entry Controller

This unit performs the hardware side of entering and leaving exception, trap and interrupt handlers in a small 32-bit processor. On every clock it looks at seven event requests from the pipeline and the interrupt logic: a reset event, an address fault, an undefined-opcode fault, a floating-point fault, a software trap carrying a 4-bit number, a system break and an already-ranked external interrupt. It accepts the most urgent one. It then loads the saved-return-PC register with a value that depends on the event type, saves the status word into its backup half and drops the interrupt enable. It also issues a one-cycle redirect to the fetch unit with the handler's vector address.

A return command from the pipeline reverses the entry. It redirects fetch to the saved return PC, rounded down to an instruction boundary, and copies the backup half of the status word into the live half. Handler software can still load the status word and the saved PC through ordinary write strobes, for example to restore them after a nested entry.

Top module: `exc_entry_unit`

## Requirements
- R1: When several requests are accepted in the same cycle, the winner follows this order: reset event, address fault, undefined opcode, floating-point fault, trap, system break, external interrupt. `cause` then reads 1, 2, 3, 4, 5, 6 or 7 for these events in that order. It reads 0 after reset and keeps its value on a return.
- R2: The redirect target is 0x00 for the reset event, 0x10 for a system break, 0x20 for an undefined opcode, 0x30 for an address fault, 0x60 for a floating-point fault and 0x80 for an external interrupt. For a trap it is 0x40 + 4 × `trapNum`, which spans 0x40 to 0x7C.
- R3: `bpc` is loaded with `curPc` for an address fault or an undefined opcode, with `curPc` + 4 for a floating-point fault or a trap, and with `nextPc` for a system break or an external interrupt. A reset event leaves `bpc` unchanged.
- R4: On any entry other than the reset event, `psw[7:4]` takes the old `psw[3:0]` and `psw[3:0]` keeps its bits except bit 0, the interrupt enable, which is cleared. The reset event clears all of `psw`.
- R5: An external interrupt is accepted only while `psw[0]` is 1. Every other request is accepted whatever `psw[0]` holds.
- R6: `redirectValid` is high for exactly one cycle, in the cycle after the request was sampled. `redirectPc`, `bpc`, `psw` and `cause` show the new values in that same cycle.
- R7: In a cycle where `redirectValid` is high, all requests, the return command and the write strobes are ignored.
- R8: A return command with no accepted event redirects to `bpc` with bits [1:0] cleared and copies `psw[7:4]` into `psw[3:0]`, leaving `psw[7:4]` unchanged. If an event is accepted in the same cycle, the event wins and the return is dropped.
- R9: In a cycle with no accepted event and no return, `pswWrEn` loads `pswWrData` into `psw` and `bpcWrEn` loads `bpcWrData` into `bpc`.
- R10: While `rstN` is low, `redirectValid`, `redirectPc`, `bpc`, `psw` and `cause` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low register reset |
| resetReq | input | 1 | Reset event request |
| addrExcReq | input | 1 | Address fault request |
| rsvdInstReq | input | 1 | Undefined opcode request |
| fpExcReq | input | 1 | Floating-point fault request |
| trapReq | input | 1 | Software trap request |
| trapNum | input | 4 | Trap number selecting the vector slot |
| sysBreakReq | input | 1 | System break request |
| extIntReq | input | 1 | Ranked external interrupt request |
| curPc | input | 32 | PC of the instruction in the accepting stage |
| nextPc | input | 32 | PC of the next instruction to execute |
| rteReq | input | 1 | Return-from-handler command |
| pswWrEn | input | 1 | Status word write strobe |
| pswWrData | input | 8 | Status word write data |
| bpcWrEn | input | 1 | Saved PC write strobe |
| bpcWrData | input | 32 | Saved PC write data |
| redirectValid | output | 1 | One-cycle fetch redirect |
| redirectPc | output | 32 | Redirect target |
| bpc | output | 32 | Saved return PC |
| psw | output | 8 | Status word: [7:4] backup, [3:0] live, bit 0 interrupt enable |
| cause | output | 3 | Code of the last accepted event |

## Verification
The bench builds the block with its default parameters: a 32-bit address, an 8-bit status word split into two 4-bit halves with the enable at bit 0, 4-byte instructions and 4-byte trap slots. With these values the first and last trap slots (0x40 and 0x7C) are reachable directly. So is the floating-point vector, which lands in the same slot as trap 8. The return path's rounding of a misaligned saved PC can be reached by a plain write of 0x307. The 4-bit live half lets the bench watch the enable bit and a neighbouring bit move separately from the backup half.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [2:0] {
    CAUSE_NONE  = 3'd0,
    CAUSE_RESET = 3'd1,
    CAUSE_ADDR  = 3'd2,
    CAUSE_RSVD  = 3'd3,
    CAUSE_FPE   = 3'd4,
    CAUSE_TRAP  = 3'd5,
    CAUSE_SBRK  = 3'd6,
    CAUSE_EXT   = 3'd7
  } cause_e;

  typedef enum logic [1:0] {
    BPC_KEEP = 2'd0,
    BPC_CUR  = 2'd1,
    BPC_CUR4 = 2'd2,
    BPC_NEXT = 2'd3
  } bpc_src_e;

  typedef struct packed {
    logic     enter;
    logic     rte;
    logic     swWrite;
    bpc_src_e bpcSrc;
    cause_e   cause;
  } strobe_t;

endpackage

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    resetReq,
  input  logic    addrExcReq,
  input  logic    rsvdInstReq,
  input  logic    fpExcReq,
  input  logic    trapReq,
  input  logic    sysBreakReq,
  input  logic    extIntReq,
  input  logic    rteReq,
  input  logic    ieFlag,
  output strobe_t stb,
  output logic    redirectValid
);

  localparam int NUM_EVT = 7;

  logic [NUM_EVT-1:0] reqVec;
  logic               anyReq;
  logic [2:0]         winIdx;
  logic               busy;

  // index 0 is the most urgent event
  assign reqVec = {extIntReq & ieFlag, sysBreakReq, trapReq, fpExcReq,
                   rsvdInstReq, addrExcReq, resetReq};
  assign anyReq = |reqVec;
  assign busy   = redirectValid;

  always_comb begin
    winIdx = 3'd0;
    for (int i = NUM_EVT - 1; i >= 0; i--) begin
      if (reqVec[i]) winIdx = 3'(i);
    end
  end

  function automatic bpc_src_e srcFor(input logic [2:0] idx);
    case (idx)
      3'd1, 3'd2: return BPC_CUR;
      3'd3, 3'd4: return BPC_CUR4;
      3'd5, 3'd6: return BPC_NEXT;
      default:    return BPC_KEEP;
    endcase
  endfunction

  always_comb begin
    stb.enter   = anyReq && !busy;
    stb.rte     = rteReq && !anyReq && !busy;
    stb.swWrite = !anyReq && !rteReq && !busy;
    stb.bpcSrc  = srcFor(winIdx);
    stb.cause   = cause_e'(winIdx + 3'd1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) redirectValid <= 1'b0;
    else       redirectValid <= stb.enter || stb.rte;
  end

endmodule

// File: rtl/exc_dpath.sv
module exc_dpath
  import exc_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          PSW_W      = 8,
  parameter int          TRAP_W     = 4,
  parameter int          IE_POS     = 0,
  parameter int          INSN_BYTES = 4,
  parameter int          SLOT_BYTES = 4,
  parameter int unsigned RESET_VEC  = 'h00,
  parameter int unsigned SBRK_VEC   = 'h10,
  parameter int unsigned RSVD_VEC   = 'h20,
  parameter int unsigned ADDR_VEC   = 'h30,
  parameter int unsigned TRAP_BASE  = 'h40,
  parameter int unsigned FPE_VEC    = 'h60,
  parameter int unsigned EXT_VEC    = 'h80
)(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [TRAP_W-1:0] trapNum,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [ADDR_W-1:0] nextPc,
  input  logic              pswWrEn,
  input  logic [PSW_W-1:0]  pswWrData,
  input  logic              bpcWrEn,
  input  logic [ADDR_W-1:0] bpcWrData,
  output logic [ADDR_W-1:0] redirectPc,
  output logic [ADDR_W-1:0] bpc,
  output logic [PSW_W-1:0]  psw,
  output logic [2:0]        cause,
  output logic              ieFlag
);

  localparam int                HALF       = PSW_W / 2;
  localparam int                SLOT_SHIFT = $clog2(SLOT_BYTES);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'(INSN_BYTES - 1);
  localparam logic [ADDR_W-1:0] INSN_STEP  = ADDR_W'(INSN_BYTES);

  logic [ADDR_W-1:0] vecAddr;
  logic [ADDR_W-1:0] rteTarget;
  logic [ADDR_W-1:0] bpcNew;
  logic [HALF-1:0]   liveMasked;
  cause_e            causeQ;

  assign ieFlag = psw[IE_POS];
  assign cause  = causeQ;

  always_comb begin
    case (stb.cause)
      CAUSE_RESET: vecAddr = ADDR_W'(RESET_VEC);
      CAUSE_ADDR:  vecAddr = ADDR_W'(ADDR_VEC);
      CAUSE_RSVD:  vecAddr = ADDR_W'(RSVD_VEC);
      CAUSE_FPE:   vecAddr = ADDR_W'(FPE_VEC);
      CAUSE_TRAP:  vecAddr = ADDR_W'(TRAP_BASE) + (ADDR_W'(trapNum) << SLOT_SHIFT);
      CAUSE_SBRK:  vecAddr = ADDR_W'(SBRK_VEC);
      default:     vecAddr = ADDR_W'(EXT_VEC);
    endcase
  end

  always_comb begin
    case (stb.bpcSrc)
      BPC_CUR:  bpcNew = curPc;
      BPC_CUR4: bpcNew = curPc + INSN_STEP;
      BPC_NEXT: bpcNew = nextPc;
      default:  bpcNew = bpc;
    endcase
  end

  assign rteTarget = bpc & ~ALIGN_MASK;

  always_comb begin
    liveMasked         = psw[HALF-1:0];
    liveMasked[IE_POS] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      redirectPc <= '0;
      bpc        <= '0;
      psw        <= '0;
      causeQ     <= CAUSE_NONE;
    end else if (stb.enter) begin
      redirectPc <= vecAddr;
      bpc        <= bpcNew;
      causeQ     <= stb.cause;
      if (stb.cause == CAUSE_RESET) psw <= '0;
      else                          psw <= {psw[HALF-1:0], liveMasked};
    end else if (stb.rte) begin
      redirectPc     <= rteTarget;
      psw[HALF-1:0]  <= psw[PSW_W-1:HALF];
    end else if (stb.swWrite) begin
      if (pswWrEn) psw <= pswWrData;
      if (bpcWrEn) bpc <= bpcWrData;
    end
  end

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          PSW_W      = 8,
  parameter int          TRAP_W     = 4,
  parameter int          IE_POS     = 0,
  parameter int          INSN_BYTES = 4,
  parameter int          SLOT_BYTES = 4,
  parameter int unsigned RESET_VEC  = 'h00,
  parameter int unsigned SBRK_VEC   = 'h10,
  parameter int unsigned RSVD_VEC   = 'h20,
  parameter int unsigned ADDR_VEC   = 'h30,
  parameter int unsigned TRAP_BASE  = 'h40,
  parameter int unsigned FPE_VEC    = 'h60,
  parameter int unsigned EXT_VEC    = 'h80
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              resetReq,
  input  logic              addrExcReq,
  input  logic              rsvdInstReq,
  input  logic              fpExcReq,
  input  logic              trapReq,
  input  logic [TRAP_W-1:0] trapNum,
  input  logic              sysBreakReq,
  input  logic              extIntReq,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [ADDR_W-1:0] nextPc,
  input  logic              rteReq,
  input  logic              pswWrEn,
  input  logic [PSW_W-1:0]  pswWrData,
  input  logic              bpcWrEn,
  input  logic [ADDR_W-1:0] bpcWrData,
  output logic              redirectValid,
  output logic [ADDR_W-1:0] redirectPc,
  output logic [ADDR_W-1:0] bpc,
  output logic [PSW_W-1:0]  psw,
  output logic [2:0]        cause
);

  strobe_t stb;
  logic    ieFlag;

  exc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .resetReq(resetReq), .addrExcReq(addrExcReq), .rsvdInstReq(rsvdInstReq),
    .fpExcReq(fpExcReq), .trapReq(trapReq), .sysBreakReq(sysBreakReq),
    .extIntReq(extIntReq), .rteReq(rteReq), .ieFlag(ieFlag),
    .stb(stb), .redirectValid(redirectValid)
  );

  exc_dpath #(
    .ADDR_W(ADDR_W), .PSW_W(PSW_W), .TRAP_W(TRAP_W), .IE_POS(IE_POS),
    .INSN_BYTES(INSN_BYTES), .SLOT_BYTES(SLOT_BYTES),
    .RESET_VEC(RESET_VEC), .SBRK_VEC(SBRK_VEC), .RSVD_VEC(RSVD_VEC),
    .ADDR_VEC(ADDR_VEC), .TRAP_BASE(TRAP_BASE), .FPE_VEC(FPE_VEC),
    .EXT_VEC(EXT_VEC)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .trapNum(trapNum),
    .curPc(curPc), .nextPc(nextPc),
    .pswWrEn(pswWrEn), .pswWrData(pswWrData),
    .bpcWrEn(bpcWrEn), .bpcWrData(bpcWrData),
    .redirectPc(redirectPc), .bpc(bpc), .psw(psw), .cause(cause),
    .ieFlag(ieFlag)
  );

endmodule

// File: rtl/exc_entry_checks.sv
module exc_entry_checks #(
  parameter int          ADDR_W     = 32,
  parameter int          PSW_W      = 8,
  parameter int          IE_POS     = 0,
  parameter int          INSN_BYTES = 4,
  parameter int unsigned ADDR_VEC   = 'h30
)(
  input logic              clk,
  input logic              rstN,
  input logic              resetReq,
  input logic              addrExcReq,
  input logic              rsvdInstReq,
  input logic              fpExcReq,
  input logic              trapReq,
  input logic              sysBreakReq,
  input logic              extIntReq,
  input logic [ADDR_W-1:0] curPc,
  input logic              rteReq,
  input logic              redirectValid,
  input logic [ADDR_W-1:0] redirectPc,
  input logic [ADDR_W-1:0] bpc,
  input logic [PSW_W-1:0]  psw,
  input logic [2:0]        cause
);

  logic noSync;
  assign noSync = !resetReq && !addrExcReq && !rsvdInstReq && !fpExcReq &&
                  !trapReq && !sysBreakReq;

  // R6: redirect pulse never lasts two cycles
  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |=> !redirectValid);

  // R7: nothing changes state during the redirect cycle
  p_hold_in_redirect_r7: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |=> ($stable(bpc) && $stable(psw) && $stable(cause)));

  // R1: reset event beats everything and clears the status word
  p_reset_wins_r1: assert property (@(posedge clk) disable iff (!rstN)
    (resetReq && !redirectValid) |=>
      (redirectValid && redirectPc == '0 && psw == '0 && cause == 3'd1));

  // R3: address fault saves the faulting PC
  p_addr_bpc_r3: assert property (@(posedge clk) disable iff (!rstN)
    (addrExcReq && !resetReq && !redirectValid) |=>
      (bpc == $past(curPc) && redirectPc == ADDR_W'(ADDR_VEC) && cause == 3'd2));

  // R5: masked external interrupt alone causes no redirect
  p_ext_masked_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!redirectValid && extIntReq && !psw[IE_POS] && noSync && !rteReq) |=>
      !redirectValid);

  // R8: lone return goes to the aligned saved PC
  p_rte_target_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!redirectValid && rteReq && noSync && !(extIntReq && psw[IE_POS])) |=>
      (redirectValid && redirectPc == ($past(bpc) & ~ADDR_W'(INSN_BYTES - 1))));

endmodule

bind exc_entry_unit exc_entry_checks #(
  .ADDR_W(ADDR_W), .PSW_W(PSW_W), .IE_POS(IE_POS),
  .INSN_BYTES(INSN_BYTES), .ADDR_VEC(ADDR_VEC)
) u_chk (.*);

// File: tb/exc_entry_unit_bench.sv
module exc_entry_unit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        resetReq = 0, addrExcReq = 0, rsvdInstReq = 0, fpExcReq = 0;
  logic        trapReq = 0, sysBreakReq = 0, extIntReq = 0, rteReq = 0;
  logic [3:0]  trapNum = '0;
  logic [31:0] curPc = '0, nextPc = '0;
  logic        pswWrEn = 0, bpcWrEn = 0;
  logic [7:0]  pswWrData = '0;
  logic [31:0] bpcWrData = '0;
  logic        redirectValid;
  logic [31:0] redirectPc, bpc;
  logic [7:0]  psw;
  logic [2:0]  cause;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  exc_entry_unit u_exc_entry_unit (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clearIn();
    resetReq = 0; addrExcReq = 0; rsvdInstReq = 0; fpExcReq = 0;
    trapReq = 0; sysBreakReq = 0; extIntReq = 0; rteReq = 0;
    pswWrEn = 0; bpcWrEn = 0;
  endtask

  function automatic logic [7:0] entered(input logic [7:0] p);
    return {p[3:0], p[3:1], 1'b0};
  endfunction

  // after one entry/return cycle: clear and let the redirect cycle pass
  task automatic settle();
    clearIn();
    tick();
    chk("R6 pulse drops", {31'd0, redirectValid}, 32'd0);
  endtask

  task automatic swWrite(input logic [7:0] p, input logic [31:0] b, input bit wb);
    pswWrEn = 1; pswWrData = p; bpcWrEn = wb; bpcWrData = b;
    tick();
    clearIn();
  endtask

  task automatic testReset();
    chk("R10 valid", {31'd0, redirectValid}, 32'd0);
    chk("R10 pc", redirectPc, 32'd0);
    chk("R10 bpc", bpc, 32'd0);
    chk("R10 psw", {24'd0, psw}, 32'd0);
    chk("R10 cause", {29'd0, cause}, 32'd0);
  endtask

  task automatic testWrites();
    swWrite(8'h05, 32'h1234, 1);
    chk("R9 psw write", {24'd0, psw}, 32'h05);
    chk("R9 bpc write", bpc, 32'h1234);
    chk("R9 no redirect", {31'd0, redirectValid}, 32'd0);
  endtask

  task automatic testExtAndReturn();
    extIntReq = 1; curPc = 32'h100; nextPc = 32'h104;
    tick();
    chk("R6 valid", {31'd0, redirectValid}, 32'd1);
    chk("R2 ext vector", redirectPc, 32'h80);
    chk("R3 ext bpc", bpc, 32'h104);
    chk("R1 ext cause", {29'd0, cause}, 32'd7);
    chk("R4 ext psw", {24'd0, psw}, {24'd0, entered(8'h05)});
    settle();
    rteReq = 1;
    tick();
    chk("R8 rte valid", {31'd0, redirectValid}, 32'd1);
    chk("R8 rte pc", redirectPc, 32'h104);
    chk("R8 rte psw", {24'd0, psw}, 32'h55);
    chk("R1 cause kept on return", {29'd0, cause}, 32'd7);
    settle();
  endtask

  task automatic testTraps();
    logic [7:0] mp;
    mp = psw;
    trapReq = 1; trapNum = 4'd15; curPc = 32'h200;
    tick();
    mp = entered(mp);
    chk("R2 trap15 vector", redirectPc, 32'h7C);
    chk("R3 trap bpc", bpc, 32'h204);
    chk("R1 trap cause", {29'd0, cause}, 32'd5);
    chk("R4 trap psw", {24'd0, psw}, {24'd0, mp});
    settle();
    trapReq = 1; trapNum = 4'd0; curPc = 32'h300;
    tick();
    mp = entered(mp);
    chk("R2 trap0 vector", redirectPc, 32'h40);
    chk("R4 second entry psw", {24'd0, psw}, {24'd0, mp});
    settle();
    trapReq = 1; trapNum = 4'd9; curPc = 32'h400;
    tick();
    chk("R2 trap9 vector", redirectPc, 32'h64);
    chk("R3 trap9 bpc", bpc, 32'h404);
    settle();
  endtask

  task automatic testMask();
    logic [7:0] p0;
    logic [31:0] b0;
    swWrite(8'h44, 32'h0, 0);
    p0 = psw; b0 = bpc;
    extIntReq = 1; curPc = 32'h500; nextPc = 32'h508;
    tick();
    chk("R5 masked no redirect", {31'd0, redirectValid}, 32'd0);
    chk("R5 masked bpc", bpc, b0);
    chk("R5 masked psw", {24'd0, psw}, {24'd0, p0});
    sysBreakReq = 1;
    tick();
    chk("R5 sbrk not masked", {31'd0, redirectValid}, 32'd1);
    chk("R2 sbrk vector", redirectPc, 32'h10);
    chk("R3 sbrk bpc", bpc, 32'h508);
    chk("R1 sbrk cause", {29'd0, cause}, 32'd6);
    settle();
  endtask

  task automatic testPriority();
    swWrite(8'h01, 32'h0, 0);
    addrExcReq = 1; rsvdInstReq = 1; fpExcReq = 1; trapReq = 1; trapNum = 4'd3;
    sysBreakReq = 1; extIntReq = 1; curPc = 32'h600; nextPc = 32'h610;
    tick();
    chk("R1 addr wins", {29'd0, cause}, 32'd2);
    chk("R2 addr vector", redirectPc, 32'h30);
    chk("R3 addr bpc", bpc, 32'h600);
    chk("R4 psw from 01", {24'd0, psw}, 32'h10);
    settle();
    rsvdInstReq = 1; fpExcReq = 1; trapReq = 1; sysBreakReq = 1; curPc = 32'h700;
    tick();
    chk("R1 rsvd wins", {29'd0, cause}, 32'd3);
    chk("R2 rsvd vector", redirectPc, 32'h20);
    chk("R3 rsvd bpc", bpc, 32'h700);
    settle();
    fpExcReq = 1; trapReq = 1; curPc = 32'h800;
    tick();
    chk("R1 fpe wins", {29'd0, cause}, 32'd4);
    chk("R2 fpe vector", redirectPc, 32'h60);
    chk("R3 fpe bpc", bpc, 32'h804);
    settle();
    trapReq = 1; trapNum = 4'd3; sysBreakReq = 1; curPc = 32'h900; nextPc = 32'h902;
    tick();
    chk("R1 trap over sbrk", {29'd0, cause}, 32'd5);
    chk("R2 trap3 vector", redirectPc, 32'h4C);
    chk("R3 trap3 bpc", bpc, 32'h904);
    settle();
  endtask

  task automatic testIgnore();
    logic [7:0] p0;
    addrExcReq = 1; curPc = 32'hA00;
    tick();
    p0 = psw;
    chk("R7 first accepted", bpc, 32'hA00);
    curPc = 32'hB00; pswWrEn = 1; pswWrData = 8'hFF; rteReq = 1;
    tick();
    chk("R7 no second redirect", {31'd0, redirectValid}, 32'd0);
    chk("R7 bpc held", bpc, 32'hA00);
    chk("R7 psw write ignored", {24'd0, psw}, {24'd0, p0});
    clearIn();
    tick();
  endtask

  task automatic testReturnEdges();
    swWrite(8'h00, 32'h307, 1);
    rteReq = 1;
    tick();
    chk("R8 aligned target", redirectPc, 32'h304);
    settle();
    rteReq = 1; sysBreakReq = 1; nextPc = 32'hC00;
    tick();
    chk("R8 event beats return", redirectPc, 32'h10);
    chk("R8 event bpc", bpc, 32'hC00);
    settle();
  endtask

  task automatic testResetEvent();
    swWrite(8'h0F, 32'h0, 0);
    resetReq = 1; addrExcReq = 1; trapReq = 1; sysBreakReq = 1; extIntReq = 1;
    curPc = 32'hD00; nextPc = 32'hD04;
    tick();
    chk("R1 reset wins", {29'd0, cause}, 32'd1);
    chk("R2 reset vector", redirectPc, 32'h0);
    chk("R4 reset clears psw", {24'd0, psw}, 32'h0);
    chk("R3 reset keeps bpc", bpc, 32'hC00);
    settle();
  endtask

  initial begin
    clearIn();
    repeat (2) tick();
    testReset();
    rstN = 1;
    tick();
    testWrites();
    testExtAndReturn();
    testTraps();
    testMask();
    testPriority();
    testIgnore();
    testReturnEdges();
    testResetEvent();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule